// File: doc/BRIEF.md
# Exclusive Access Monitor

This block guards read-modify-write sequences issued by one local requester on a shared memory bus. A load-exclusive takes out a reservation on the word it reads, together with the access size. A later store-exclusive is let through to memory only while that reservation is still held and the store names the same word and size. Every store-exclusive produces a status bit for the requester: 0 means the store was performed, 1 means it was suppressed and the sequence must be retried. Software can therefore run a lock-free retry loop on the data word itself, with no bus lock and no separate test-and-set flag.

The reservation is lost whenever another agent could have changed the word. Snooped writes from other bus masters to any byte of the reserved word drop it. A clear-exclusive request drops it. Entry to an exception handler drops it, so an interrupt routine that touches the word always makes the interrupted sequence fail. Matching is done on the word-aligned address.

The controller has two states. MON_OPEN means no reservation is held. MON_ARMED means a word and size are reserved. The transitions are:

- ARM (OPEN to ARMED): an aligned load-exclusive with no clear, exception or snoop hit on its own word.
- RELOAD (ARMED to ARMED): such a load-exclusive while a reservation is already held.
- DROP (ARMED to OPEN): any store-exclusive, a failed load-exclusive, a clear, an exception entry, or a snoop hit on the reserved word.
- HOLD: every other cycle.

Top module: `excl_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mon_armed`, `wr_grant`, `stx_done` and `stx_status` are all 0.
- R2: An aligned load-exclusive (`req_kind`=2'b10) raises `mon_armed` in the cycle after the request and reserves that word and size. The size codes are 0=byte, 1=halfword, 2=word and 3=reserved. The word address is `req_addr` with its two low bits dropped.
- R3: A store-exclusive (`req_kind`=2'b11) issued while armed, with the same word and size and no disarming event in that cycle, gives `wr_grant`=1, `stx_done`=1 and `stx_status`=0 in the next cycle.
- R4: A store-exclusive issued while disarmed, or to a different word, or with a different size, gives `stx_done`=1, `stx_status`=1 and `wr_grant`=0 in the next cycle.
- R5: Every store-exclusive, whether it succeeds or fails, leaves `mon_armed` at 0 in the next cycle.
- R6: A snooped write (`snp_valid`) to any byte of the reserved word clears the reservation. A store-exclusive in the same cycle as such a snoop fails.
- R7: `clear_excl` or `exc_entry` clears the reservation in the next cycle. A store-exclusive in the same cycle as either one fails.
- R8: A misaligned exclusive access fails. This covers a halfword at an odd address, a word whose address is not a multiple of 4, and size code 3. A misaligned load-exclusive leaves the monitor disarmed, and a misaligned store-exclusive returns status 1 with no write.
- R9: Plain loads (2'b00) and plain stores (2'b01) leave the reservation unchanged. A plain store always gives `wr_grant`=1 and `stx_done`=0 in the next cycle.
- R10: A load-exclusive issued while armed replaces the reservation, so a later store-exclusive to the old word fails.
- R11: A snooped write to a different word leaves the reservation in place.
- R12: A load-exclusive in the same cycle as `clear_excl`, `exc_entry`, or a snoop to its own word leaves the monitor disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present this cycle |
| req_kind | input | 2 | 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| clear_excl | input | 1 | Explicit request to drop the reservation |
| exc_entry | input | 1 | Exception entry pulse |
| snp_valid | input | 1 | Write by another master observed |
| snp_addr | input | ADDR_W | Byte address of the snooped write |
| wr_grant | output | 1 | Store may update memory (one cycle after request) |
| stx_done | output | 1 | Store-exclusive result valid |
| stx_status | output | 1 | 0 success, 1 failure |
| mon_armed | output | 1 | Reservation held |

## Verification
The bound assertions check on every cycle the properties that depend only on port values. A success is always a write and always follows an armed cycle. A failure never writes. Each store-exclusive, clear or exception leaves the monitor disarmed. Plain stores are always granted, and arming only ever follows a load-exclusive. Whether a store succeeds also depends on which word and size are held, and that state is not visible at the ports. Word and size matching, snoop hits on other bytes of the word, replacement by a new load-exclusive, and the same-cycle races are therefore shown only by the bench's directed and random sequences, compared against a reference model.

// File: rtl/excl_pkg.sv
package excl_pkg;

    typedef enum logic [1:0] {
        RK_LOAD  = 2'b00,
        RK_STORE = 2'b01,
        RK_LDX   = 2'b10,
        RK_STX   = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        MON_OPEN  = 1'b0,
        MON_ARMED = 1'b1
    } mon_state_e;

endpackage

// File: rtl/excl_req_decode.sv
module excl_req_decode
    import excl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 2,
    localparam int WA_W     = ADDR_W - GRAN_LOG2
) (
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              is_ldx,
    output logic              is_stx,
    output logic              is_plain_st,
    output logic              aligned,
    output logic [WA_W-1:0]   req_word
);

    typedef logic [GRAN_LOG2-1:0] low_t;

    low_t      low_bits;
    low_t      size_mask;
    req_kind_e kind;

    always_comb begin
        kind        = req_kind_e'(req_kind);
        is_ldx      = req_valid && (kind == RK_LDX);
        is_stx      = req_valid && (kind == RK_STX);
        is_plain_st = req_valid && (kind == RK_STORE);
    end

    always_comb begin
        low_bits  = req_addr[GRAN_LOG2-1:0];
        size_mask = low_t'((32'd1 << req_size) - 32'd1);
        aligned   = (acc_size_e'(req_size) != SZ_RSVD) &&
                    ((low_bits & size_mask) == '0);
        req_word  = req_addr[ADDR_W-1:GRAN_LOG2];
    end

endmodule

// File: rtl/excl_match.sv
module excl_match #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 2,
    localparam int WA_W     = ADDR_W - GRAN_LOG2
) (
    input  logic              armed,
    input  logic [WA_W-1:0]   resv_word,
    input  logic [1:0]        resv_size,
    input  logic [WA_W-1:0]   req_word,
    input  logic [1:0]        req_size,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              req_hits_resv,
    output logic              snp_hits_resv,
    output logic              snp_hits_req
);

    logic [WA_W-1:0] snp_word;
    logic            unused_snp_low;

    assign snp_word       = snp_addr[ADDR_W-1:GRAN_LOG2];
    assign unused_snp_low = ^snp_addr[GRAN_LOG2-1:0];

    always_comb begin
        req_hits_resv = armed && (req_word == resv_word) && (req_size == resv_size);
        snp_hits_resv = armed && snp_valid && (snp_word == resv_word);
        snp_hits_req  = snp_valid && (snp_word == req_word);
    end

endmodule

// File: rtl/excl_fsm.sv
module excl_fsm
    import excl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 2,
    localparam int WA_W     = ADDR_W - GRAN_LOG2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_ldx,
    input  logic            is_stx,
    input  logic            is_plain_st,
    input  logic            aligned,
    input  logic [WA_W-1:0] req_word,
    input  logic [1:0]      req_size,
    input  logic            clear_excl,
    input  logic            exc_entry,
    input  logic            req_hits_resv,
    input  logic            snp_hits_resv,
    input  logic            snp_hits_req,
    output logic            armed,
    output logic [WA_W-1:0] resv_word,
    output logic [1:0]      resv_size,
    output logic            wr_grant,
    output logic            stx_done,
    output logic            stx_status
);

    mon_state_e st_q, st_n;
    logic       kill;
    logic       ldx_take;
    logic       load_resv;
    logic       stx_ok;

    assign armed = (st_q == MON_ARMED);

    always_comb begin
        kill     = clear_excl || exc_entry || snp_hits_resv;
        ldx_take = is_ldx && aligned && !clear_excl && !exc_entry && !snp_hits_req;
        stx_ok   = is_stx && armed && aligned && req_hits_resv && !kill;
    end

    always_comb begin
        st_n      = st_q;
        load_resv = 1'b0;
        unique case (st_q)
            MON_OPEN: begin
                if (ldx_take) begin
                    st_n      = MON_ARMED;
                    load_resv = 1'b1;
                end
            end
            MON_ARMED: begin
                if (is_ldx) begin
                    if (ldx_take) begin
                        load_resv = 1'b1;
                    end else begin
                        st_n = MON_OPEN;
                    end
                end else if (is_stx || kill) begin
                    st_n = MON_OPEN;
                end
            end
            default: st_n = MON_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= MON_OPEN;
            resv_word <= '0;
            resv_size <= '0;
        end else begin
            st_q <= st_n;
            if (load_resv) begin
                resv_word <= req_word;
                resv_size <= req_size;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_grant   <= 1'b0;
            stx_done   <= 1'b0;
            stx_status <= 1'b0;
        end else begin
            wr_grant   <= is_plain_st || stx_ok;
            stx_done   <= is_stx;
            stx_status <= is_stx && !stx_ok;
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              clear_excl,
    input  logic              exc_entry,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              wr_grant,
    output logic              stx_done,
    output logic              stx_status,
    output logic              mon_armed
);

    localparam int WA_W = ADDR_W - GRAN_LOG2;

    logic            is_ldx, is_stx, is_plain_st, aligned;
    logic [WA_W-1:0] req_word, resv_word;
    logic [1:0]      resv_size;
    logic            armed;
    logic            req_hits_resv, snp_hits_resv, snp_hits_req;

    excl_req_decode #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_dec (
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .is_ldx      (is_ldx),
        .is_stx      (is_stx),
        .is_plain_st (is_plain_st),
        .aligned     (aligned),
        .req_word    (req_word)
    );

    excl_match #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
        .armed         (armed),
        .resv_word     (resv_word),
        .resv_size     (resv_size),
        .req_word      (req_word),
        .req_size      (req_size),
        .snp_valid     (snp_valid),
        .snp_addr      (snp_addr),
        .req_hits_resv (req_hits_resv),
        .snp_hits_resv (snp_hits_resv),
        .snp_hits_req  (snp_hits_req)
    );

    excl_fsm #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .is_ldx        (is_ldx),
        .is_stx        (is_stx),
        .is_plain_st   (is_plain_st),
        .aligned       (aligned),
        .req_word      (req_word),
        .req_size      (req_size),
        .clear_excl    (clear_excl),
        .exc_entry     (exc_entry),
        .req_hits_resv (req_hits_resv),
        .snp_hits_resv (snp_hits_resv),
        .snp_hits_req  (snp_hits_req),
        .armed         (armed),
        .resv_word     (resv_word),
        .resv_size     (resv_size),
        .wr_grant      (wr_grant),
        .stx_done      (stx_done),
        .stx_status    (stx_status)
    );

    assign mon_armed = armed;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic [1:0] req_size,
    input logic       clear_excl,
    input logic       exc_entry,
    input logic       wr_grant,
    input logic       stx_done,
    input logic       stx_status,
    input logic       mon_armed
);

    a_r2_arm_from_ldx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_armed) |-> $past(req_valid && req_kind == 2'b10));

    a_r3_ok_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_done && !stx_status) |-> wr_grant);

    a_r3_ok_was_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_done && !stx_status) |-> $past(mon_armed));

    a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stx_done && stx_status) |-> !wr_grant);

    a_r4_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11 && !mon_armed) |=> (stx_done && stx_status));

    a_r5_stx_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11) |=> !mon_armed);

    a_r7_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_excl || exc_entry) |=> !mon_armed);

    a_r8_rsvd_size_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10 && req_size == 2'd3) |=> !mon_armed);

    a_r9_plain_store_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01) |=> (wr_grant && !stx_done));

endmodule

bind excl_monitor excl_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_size   (req_size),
    .clear_excl (clear_excl),
    .exc_entry  (exc_entry),
    .wr_grant   (wr_grant),
    .stx_done   (stx_done),
    .stx_status (stx_status),
    .mon_armed  (mon_armed)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'd0;
    logic        clear_excl = 1'b0;
    logic        exc_entry = 1'b0;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        wr_grant, stx_done, stx_status, mon_armed;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic        m_armed = 1'b0;
    logic [29:0] m_word = '0;
    logic [1:0]  m_size = '0;

    localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LDX = 2'b10, K_STX = 2'b11;
    localparam logic [1:0] S_B = 2'd0, S_H = 2'd1, S_W = 2'd2;
    localparam logic [31:0] A = 32'h2000_0010;
    localparam logic [31:0] B = 32'h2000_0020;

    always #4 clk = ~clk;

    excl_monitor u_excl_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .clear_excl(clear_excl),
        .exc_entry(exc_entry), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .wr_grant(wr_grant), .stx_done(stx_done), .stx_status(stx_status),
        .mon_armed(mon_armed)
    );

    function automatic logic is_aligned(input logic [31:0] a, input logic [1:0] s);
        case (s)
            2'd0:    return 1'b1;
            2'd1:    return a[0] == 1'b0;
            2'd2:    return a[1:0] == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {grant,done,status,armed} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [1:0] k,
                        input logic [31:0] a, input logic [1:0] s,
                        input logic clr, input logic exc,
                        input logic sv, input logic [31:0] sa);
        logic ok, kill, grant, done, status, n_armed;
        logic [29:0] n_word;
        logic [1:0]  n_size;
        req_valid = v; req_kind = k; req_addr = a; req_size = s;
        clear_excl = clr; exc_entry = exc; snp_valid = sv; snp_addr = sa;
        kill   = clr || exc || (m_armed && sv && sa[31:2] == m_word);
        ok     = v && k == K_STX && m_armed && is_aligned(a, s) &&
                 a[31:2] == m_word && s == m_size && !kill;
        grant  = v && (k == K_ST || ok);
        done   = v && k == K_STX;
        status = done && !ok;
        n_armed = m_armed; n_word = m_word; n_size = m_size;
        if (v && k == K_LDX) begin
            if (is_aligned(a, s) && !clr && !exc && !(sv && sa[31:2] == a[31:2])) begin
                n_armed = 1'b1; n_word = a[31:2]; n_size = s;
            end else begin
                n_armed = 1'b0;
            end
        end else if ((v && k == K_STX) || kill) begin
            n_armed = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        m_armed = n_armed; m_word = n_word; m_size = n_size;
        check(tag, {wr_grant, stx_done, stx_status, mon_armed}, {grant, done, status, n_armed});
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, K_LD, '0, S_B, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic req(input string tag, input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
        step(tag, 1'b1, k, a, s, 1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 in reset", {wr_grant, stx_done, stx_status, mon_armed}, 4'b0000);
        rst_n = 1'b1;
        idle("R1 after reset");

        req("R2 arm word", K_LDX, A, S_W);
        req("R3 stx success", K_STX, A, S_W);
        req("R5 R4 stx after stx", K_STX, A, S_W);

        req("R2", K_LDX, A, S_W);
        req("R4 other word", K_STX, A + 4, S_W);
        req("R2", K_LDX, A, S_W);
        req("R4 other size", K_STX, A, S_H);

        req("R2", K_LDX, A, S_W);
        step("R6 snoop other byte", 1'b0, K_LD, '0, S_B, 1'b0, 1'b0, 1'b1, A + 3);
        req("R6 stx after snoop", K_STX, A, S_W);
        req("R2", K_LDX, A, S_W);
        step("R6 snoop same cycle", 1'b1, K_STX, A, S_W, 1'b0, 1'b0, 1'b1, A + 1);

        req("R2", K_LDX, A, S_W);
        step("R7 clear", 1'b0, K_LD, '0, S_B, 1'b1, 1'b0, 1'b0, '0);
        req("R2", K_LDX, A, S_W);
        step("R7 exc with stx", 1'b1, K_STX, A, S_W, 1'b0, 1'b1, 1'b0, '0);
        req("R2", K_LDX, A, S_W);
        step("R7 exc entry", 1'b0, K_LD, '0, S_B, 1'b0, 1'b1, 1'b0, '0);

        req("R8 odd half ldx", K_LDX, A + 1, S_H);
        req("R8 rsvd size ldx", K_LDX, A, 2'd3);
        req("R2", K_LDX, A, S_W);
        req("R8 misaligned stx", K_STX, A + 2, S_W);

        req("R2", K_LDX, A, S_W);
        req("R9 plain load", K_LD, A, S_W);
        req("R9 plain store", K_ST, A, S_W);
        req("R9 stx still ok", K_STX, A, S_W);

        req("R2", K_LDX, A, S_W);
        req("R10 reload", K_LDX, B, S_W);
        req("R10 old word fails", K_STX, A, S_W);
        req("R2", K_LDX, A, S_W);
        req("R10 reload", K_LDX, B, S_W);
        req("R10 new word ok", K_STX, B, S_W);

        req("R2", K_LDX, A, S_W);
        step("R11 snoop far", 1'b0, K_LD, '0, S_B, 1'b0, 1'b0, 1'b1, B);
        req("R11 stx ok", K_STX, A, S_W);

        step("R12 ldx with snoop", 1'b1, K_LDX, A, S_W, 1'b0, 1'b0, 1'b1, A + 2);
        step("R12 ldx with clear", 1'b1, K_LDX, A, S_W, 1'b1, 1'b0, 1'b0, '0);
        step("R12 ldx with exc", 1'b1, K_LDX, A, S_W, 1'b0, 1'b1, 1'b0, '0);

        req("R2 byte", K_LDX, A + 3, S_B);
        req("R3 byte same word", K_STX, A + 1, S_B);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            step("random mix", r[0] | r[1], r[3:2], 32'h2000_0000 + {28'd0, r[7:4]},
                 (r[9:8] == 2'd3 && r[10]) ? 2'd3 : {1'b0, r[8]} + {1'b0, r[9]},
                 r[15:11] == 5'd0, r[20:16] == 5'd0,
                 r[23:21] == 3'd0, 32'h2000_0000 + {28'd0, r[27:24]});
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule